// File: doc/BRIEF.md
# SDRAM Command Decoder and Legality Checker

This block sits on the device side of a four-bank SDRAM command bus and samples it on every rising clock edge. It turns the chip-select, row-strobe, column-strobe, write-enable and clock-enable levels into one command code. It keeps an open or precharged flag for each bank, and it raises an illegal-command strobe whenever a command breaks the rules that apply in the present state. A rejected command changes no state. The block also times the data mask: it reports the write mask for the current edge and a read high-impedance flag two clocks later.

Every output is registered. The outputs seen after edge n describe the command sampled at edge n, and the bank flags show the state after that edge. A design that drives the bus can attach the block as a protocol watchdog, or a memory model can use it as its front end.

Top module: `sdcmd_mon`

## Requirements
- R1: `cmdCode` shows the command sampled at the previous edge. The commands and their codes are:
  - NOP=0, for pins 111, for `csN` high, and for any cycle with `ckePrev` low.
  - MRS=1, for pins 000.
  - REF=2, for pins 001 with `ckeCur` high.
  - SREF=3, for pins 001 with `ckeCur` low.
  - ACT=4, for pins 011.
  - RD=5 and RDA=7, for pins 101.
  - WR=6 and WRA=8, for pins 100.
  - PRE=9 and PALL=10, for pins 010.
  - RSVD=11, for pins 110.

  The pins are written in the order {rasN,casN,weN}, and all of these apply with `csN` low.
- R2: For ACT, RD, WR, RDA, WRA and PRE, `cmdBank` equals BA, and BA values 0 to 3 select banks 0 to 3. For every other command `cmdBank` is 0.
- R3: A legal PRE closes only the bank addressed by BA. A legal PALL closes all banks and ignores BA.
- R4: With A10/AP low, a read or write decodes as RD or WR, with no automatic close. With A10/AP high it decodes as RDA or WRA. A legal RDA or WRA accepted at edge s closes its bank at edge s+BL.
- R5: After a legal MRS at edge n, any command other than NOP sampled at edge n+1 is illegal. Commands are accepted again from edge n+2.
- R6: MRS, REF and SREF are illegal unless every bank is precharged.
- R7: Take an RDA or WRA accepted at edge s. Any RD, WR, RDA or WRA at edges s+1 to s+BL-1 is illegal. At edge s+BL a read or write to another open bank is legal, while one to the closing bank is illegal. BL is taken from operand bits [2:0] of the last legal MRS: 000 gives 1, 001 gives 2, 010 gives 4, 011 gives 8, and values 1xx give 1. BL is 1 after reset.
- R8: These commands are illegal:
  - an ACT to an open bank;
  - an RD, WR, RDA or WRA to a precharged bank.

  An illegal command sets `illegalCmd` for one cycle and does not change bank state, BL or the MRS lockout. A legal ACT opens its bank.
- R9: During and after reset all banks are precharged, the lockout is clear, `cmdCode` is NOP, and `illegalCmd`, `wrMask` and `rdHiZ` are 0.
- R10: `wrMask` equals the DQM value sampled at the previous edge, which is the mask for data sampled on that same edge. `rdHiZ` carries the same DQM value two cycles after `wrMask` does.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock, rising edge samples |
| rstN | input | 1 | Active-low synchronous reset |
| ckePrev | input | 1 | Clock enable as seen in the previous cycle |
| ckeCur | input | 1 | Clock enable in the current cycle |
| csN | input | 1 | Chip select, active low |
| rasN | input | 1 | Row strobe, active low |
| casN | input | 1 | Column strobe, active low |
| weN | input | 1 | Write enable, active low |
| ba | input | 2 | Bank address |
| apBit | input | 1 | A10/AP: auto precharge or all-bank select |
| modeOp | input | 3 | Burst-length field of the mode operand |
| dqm | input | 1 | Data mask |
| cmdCode | output | 4 | Decoded command code |
| cmdBank | output | 2 | Target bank of the decoded command |
| bankOpen | output | 4 | Per-bank open flag, bit i for bank i |
| illegalCmd | output | 1 | One-cycle strobe for a rejected command |
| wrMask | output | 1 | Write data mask, latency 0 |
| rdHiZ | output | 1 | Read output high-impedance, latency 2 |

## Verification
The hardest case to reach is the burst-length boundary of an auto-precharge read. On that single edge one bank is closing, a read to a different bank must be accepted, and a read to the closing bank must be rejected. To reach it, the stimulus first programs a burst length of four through a legal MRS that respects the lockout. It then opens two banks, issues RDA on one bank, and places a blocked read inside the burst. A legal read to the second bank follows at the boundary, and a read to the first bank comes one edge later. A second pass with a burst length of one moves the boundary onto the very next edge.

// File: rtl/sdcmd_pkg.sv
package sdcmd_pkg;

  typedef enum logic [3:0] {
    CMD_NOP  = 4'd0,
    CMD_MRS  = 4'd1,
    CMD_REF  = 4'd2,
    CMD_SREF = 4'd3,
    CMD_ACT  = 4'd4,
    CMD_RD   = 4'd5,
    CMD_WR   = 4'd6,
    CMD_RDA  = 4'd7,
    CMD_WRA  = 4'd8,
    CMD_PRE  = 4'd9,
    CMD_PALL = 4'd10,
    CMD_RSVD = 4'd11
  } cmd_e;

  typedef struct packed {
    logic illegal;
    logic usesBank;
    logic doAct;
    logic doClose;
    logic doCloseAll;
    logic doMrs;
    logic doAuto;
  } strobe_t;

endpackage

// File: rtl/sdcmd_ctrl.sv
module sdcmd_ctrl
  import sdcmd_pkg::*;
#(
  parameter int NUM_BANKS = 4,
  localparam int BA_W = $clog2(NUM_BANKS)
) (
  input  logic                 ckePrev,
  input  logic                 ckeCur,
  input  logic                 csN,
  input  logic                 rasN,
  input  logic                 casN,
  input  logic                 weN,
  input  logic                 apBit,
  input  logic [BA_W-1:0]      ba,
  input  logic [NUM_BANKS-1:0] bankOpen,
  input  logic [NUM_BANKS-1:0] bankAvail,
  input  logic                 lockBusy,
  input  logic                 burstBusy,
  output cmd_e                 cmd,
  output strobe_t              stb
);

  logic bad;

  always_comb begin
    cmd = CMD_NOP;
    if (ckePrev && !csN) begin
      unique case ({rasN, casN, weN})
        3'b000:  cmd = CMD_MRS;
        3'b001:  cmd = ckeCur ? CMD_REF : CMD_SREF;
        3'b011:  cmd = CMD_ACT;
        3'b101:  cmd = apBit ? CMD_RDA : CMD_RD;
        3'b100:  cmd = apBit ? CMD_WRA : CMD_WR;
        3'b010:  cmd = apBit ? CMD_PALL : CMD_PRE;
        3'b110:  cmd = CMD_RSVD;
        default: cmd = CMD_NOP;
      endcase
    end
  end

  always_comb begin
    bad = 1'b0;
    unique case (cmd)
      CMD_MRS, CMD_REF, CMD_SREF: bad = (bankOpen != '0);
      CMD_ACT:                    bad = bankOpen[ba];
      CMD_RD, CMD_WR, CMD_RDA, CMD_WRA: bad = !bankAvail[ba] || burstBusy;
      default:                    bad = 1'b0;
    endcase
    if (lockBusy && cmd != CMD_NOP) bad = 1'b1;
  end

  always_comb begin
    stb.illegal    = bad;
    stb.usesBank   = cmd inside {CMD_ACT, CMD_RD, CMD_WR, CMD_RDA, CMD_WRA, CMD_PRE};
    stb.doAct      = (cmd == CMD_ACT) && !bad;
    stb.doClose    = (cmd == CMD_PRE) && !bad;
    stb.doCloseAll = (cmd == CMD_PALL) && !bad;
    stb.doMrs      = (cmd == CMD_MRS) && !bad;
    stb.doAuto     = (cmd == CMD_RDA || cmd == CMD_WRA) && !bad;
  end

endmodule

// File: rtl/sdcmd_dp.sv
module sdcmd_dp
  import sdcmd_pkg::*;
#(
  parameter int NUM_BANKS = 4,
  parameter int MAX_BL    = 8,
  parameter int MRS_GAP   = 2,
  parameter int RD_LAT    = 2,
  localparam int BA_W   = $clog2(NUM_BANKS),
  localparam int CNT_W  = $clog2(MAX_BL + 1),
  localparam int LOCK_W = $clog2(MRS_GAP + 1)
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  strobe_t              stb,
  input  cmd_e                 cmd,
  input  logic [BA_W-1:0]      ba,
  input  logic [2:0]           modeBl,
  input  logic                 dqm,
  output logic [NUM_BANKS-1:0] bankOpen,
  output logic [NUM_BANKS-1:0] bankAvail,
  output logic                 lockBusy,
  output logic                 burstBusy,
  output logic [3:0]           cmdCode,
  output logic [BA_W-1:0]      cmdBank,
  output logic                 illegalCmd,
  output logic                 wrMask,
  output logic                 rdHiZ
);

  logic [LOCK_W-1:0] lockCnt;
  logic [CNT_W-1:0]  apCnt;
  logic [CNT_W-1:0]  blReg;
  logic [BA_W-1:0]   apBank;
  logic [RD_LAT:0]   dqmPipe;
  logic              closeNow;

  assign lockBusy  = (lockCnt != '0);
  assign burstBusy = (apCnt > CNT_W'(1));
  assign closeNow  = (apCnt == CNT_W'(1));

  for (genvar i = 0; i < NUM_BANKS; i++) begin : g_bank
    logic hitCmd;
    logic hitAuto;
    assign hitCmd  = (ba == BA_W'(i));
    assign hitAuto = closeNow && (apBank == BA_W'(i));
    assign bankAvail[i] = bankOpen[i] && !hitAuto;

    always_ff @(posedge clk) begin
      if (!rstN)
        bankOpen[i] <= 1'b0;
      else if (stb.doAct && hitCmd)
        bankOpen[i] <= 1'b1;
      else if (stb.doCloseAll || (stb.doClose && hitCmd) || hitAuto)
        bankOpen[i] <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      lockCnt <= '0;
      apCnt   <= '0;
      apBank  <= '0;
      blReg   <= CNT_W'(1);
    end else begin
      if (stb.doMrs)
        lockCnt <= LOCK_W'(MRS_GAP - 1);
      else if (lockBusy)
        lockCnt <= lockCnt - LOCK_W'(1);

      if (stb.doMrs)
        blReg <= modeBl[2] ? CNT_W'(1) : (CNT_W'(1) << modeBl[1:0]);

      if (stb.doAuto) begin
        apCnt  <= blReg;
        apBank <= ba;
      end else if (apCnt != '0) begin
        apCnt <= apCnt - CNT_W'(1);
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      cmdCode    <= CMD_NOP;
      cmdBank    <= '0;
      illegalCmd <= 1'b0;
      dqmPipe    <= '0;
    end else begin
      cmdCode    <= cmd;
      cmdBank    <= stb.usesBank ? ba : '0;
      illegalCmd <= stb.illegal;
      dqmPipe    <= {dqmPipe[RD_LAT-1:0], dqm};
    end
  end

  assign wrMask = dqmPipe[0];
  assign rdHiZ  = dqmPipe[RD_LAT];

endmodule

// File: rtl/sdcmd_mon.sv
module sdcmd_mon
  import sdcmd_pkg::*;
#(
  parameter int NUM_BANKS = 4,
  parameter int MAX_BL    = 8,
  parameter int MRS_GAP   = 2,
  parameter int RD_LAT    = 2,
  localparam int BA_W = $clog2(NUM_BANKS)
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 ckePrev,
  input  logic                 ckeCur,
  input  logic                 csN,
  input  logic                 rasN,
  input  logic                 casN,
  input  logic                 weN,
  input  logic [BA_W-1:0]      ba,
  input  logic                 apBit,
  input  logic [2:0]           modeOp,
  input  logic                 dqm,
  output logic [3:0]           cmdCode,
  output logic [BA_W-1:0]      cmdBank,
  output logic [NUM_BANKS-1:0] bankOpen,
  output logic                 illegalCmd,
  output logic                 wrMask,
  output logic                 rdHiZ
);

  cmd_e                 cmd;
  strobe_t              stb;
  logic [NUM_BANKS-1:0] bankAvail;
  logic                 lockBusy;
  logic                 burstBusy;

  sdcmd_ctrl #(.NUM_BANKS(NUM_BANKS)) ctrl_i (
    .ckePrev  (ckePrev),
    .ckeCur   (ckeCur),
    .csN      (csN),
    .rasN     (rasN),
    .casN     (casN),
    .weN      (weN),
    .apBit    (apBit),
    .ba       (ba),
    .bankOpen (bankOpen),
    .bankAvail(bankAvail),
    .lockBusy (lockBusy),
    .burstBusy(burstBusy),
    .cmd      (cmd),
    .stb      (stb)
  );

  sdcmd_dp #(
    .NUM_BANKS(NUM_BANKS),
    .MAX_BL   (MAX_BL),
    .MRS_GAP  (MRS_GAP),
    .RD_LAT   (RD_LAT)
  ) dp_i (
    .clk       (clk),
    .rstN      (rstN),
    .stb       (stb),
    .cmd       (cmd),
    .ba        (ba),
    .modeBl    (modeOp),
    .dqm       (dqm),
    .bankOpen  (bankOpen),
    .bankAvail (bankAvail),
    .lockBusy  (lockBusy),
    .burstBusy (burstBusy),
    .cmdCode   (cmdCode),
    .cmdBank   (cmdBank),
    .illegalCmd(illegalCmd),
    .wrMask    (wrMask),
    .rdHiZ     (rdHiZ)
  );

endmodule

// File: rtl/sdcmd_chk.sv
module sdcmd_chk
  import sdcmd_pkg::*;
#(
  parameter int NUM_BANKS = 4,
  localparam int BA_W = $clog2(NUM_BANKS)
) (
  input logic                 clk,
  input logic                 rstN,
  input logic                 dqm,
  input logic [3:0]           cmdCode,
  input logic [BA_W-1:0]      cmdBank,
  input logic [NUM_BANKS-1:0] bankOpen,
  input logic                 illegalCmd,
  input logic                 wrMask,
  input logic                 rdHiZ
);

  logic [NUM_BANKS-1:0] prevOpen;
  logic                 accepted;

  always_ff @(posedge clk) begin
    if (!rstN) prevOpen <= '0;
    else       prevOpen <= bankOpen;
  end

  assign accepted = !illegalCmd;

  p_mrs_lockout_r5: assert property (@(posedge clk) disable iff (!rstN)
    (cmdCode == CMD_MRS && accepted) |=> (cmdCode == CMD_NOP || illegalCmd));

  p_all_precharged_r6: assert property (@(posedge clk) disable iff (!rstN)
    ((cmdCode == CMD_MRS || cmdCode == CMD_REF || cmdCode == CMD_SREF) && accepted)
      |-> (prevOpen == '0));

  p_act_closed_r8: assert property (@(posedge clk) disable iff (!rstN)
    (cmdCode == CMD_ACT && accepted) |-> (!prevOpen[cmdBank] && bankOpen[cmdBank]));

  p_access_open_r8: assert property (@(posedge clk) disable iff (!rstN)
    ((cmdCode == CMD_RD || cmdCode == CMD_WR || cmdCode == CMD_RDA || cmdCode == CMD_WRA)
      && accepted) |-> prevOpen[cmdBank]);

  p_close_all_r3: assert property (@(posedge clk) disable iff (!rstN)
    (cmdCode == CMD_PALL && accepted) |-> (bankOpen == '0));

  p_write_mask_r10: assert property (@(posedge clk) disable iff (!rstN)
    $past(rstN) |-> (wrMask == $past(dqm)));

  p_read_hiz_r10: assert property (@(posedge clk) disable iff (!rstN)
    ($past(rstN) && $past(rstN, 2) && $past(rstN, 3)) |-> (rdHiZ == $past(wrMask, 2)));

endmodule

bind sdcmd_mon sdcmd_chk #(.NUM_BANKS(NUM_BANKS)) chk_i (.*);

// File: tb/sdcmd_mon_tb_top.sv
module sdcmd_mon_tb_top;

  localparam int C_NOP = 0, C_MRS = 1, C_REF = 2, C_SREF = 3, C_ACT = 4,
                 C_RD = 5, C_WR = 6, C_RDA = 7, C_WRA = 8, C_PRE = 9,
                 C_PALL = 10, C_RSVD = 11, C_DESEL = 15;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       ckePrev = 1'b1, ckeCur = 1'b1, csN = 1'b1;
  logic       rasN = 1'b1, casN = 1'b1, weN = 1'b1, apBit = 1'b0;
  logic [1:0] ba = '0;
  logic [2:0] modeOp = '0;
  logic       dqm = 1'b0;
  logic [3:0] cmdCode;
  logic [1:0] cmdBank;
  logic [3:0] bankOpen;
  logic       illegalCmd, wrMask, rdHiZ;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  logic [12:0] expQ[$];
  string       tagQ[$];

  // bench reference state
  logic [3:0] mOpen = '0;
  int         mLock = 0, mAp = 0, mApBank = 0, mBl = 1;
  logic       h1 = 1'b0, h2 = 1'b0;

  always #5 clk = ~clk;

  sdcmd_mon dut_i (
    .clk(clk), .rstN(rstN), .ckePrev(ckePrev), .ckeCur(ckeCur), .csN(csN),
    .rasN(rasN), .casN(casN), .weN(weN), .ba(ba), .apBit(apBit),
    .modeOp(modeOp), .dqm(dqm), .cmdCode(cmdCode), .cmdBank(cmdBank),
    .bankOpen(bankOpen), .illegalCmd(illegalCmd), .wrMask(wrMask), .rdHiZ(rdHiZ)
  );

  task automatic compare(input logic [12:0] act, input logic [12:0] exp, input string tag);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual code=%0d bank=%0d open=%b ill=%b wm=%b hz=%b expected code=%0d bank=%0d open=%b ill=%b wm=%b hz=%b",
               tag, act[12:9], act[8:7], act[6:3], act[2], act[1], act[0],
               exp[12:9], exp[8:7], exp[6:3], exp[2], exp[1], exp[0]);
    end
  endtask

  // driver: one call = one sampling edge
  task automatic issue(input int c, input int bank, input bit dq, input string tag,
                       input bit ckp = 1'b1);
    int  e;
    bit  bad, openSel, avail, uses;
    logic [2:0] pins;
    @(negedge clk);
    ckePrev = ckp;
    ckeCur  = (c == C_SREF) ? 1'b0 : 1'b1;
    csN     = (c == C_DESEL);
    apBit   = (c == C_RDA || c == C_WRA || c == C_PALL);
    ba      = bank[1:0];
    dqm     = dq;
    case (c)
      C_MRS:           pins = 3'b000;
      C_REF, C_SREF:   pins = 3'b001;
      C_ACT:           pins = 3'b011;
      C_RD, C_RDA:     pins = 3'b101;
      C_WR, C_WRA:     pins = 3'b100;
      C_PRE, C_PALL:   pins = 3'b010;
      C_RSVD:          pins = 3'b110;
      default:         pins = 3'b111;
    endcase
    {rasN, casN, weN} = pins;

    e = (!ckp || c == C_DESEL) ? C_NOP : c;
    uses = (e >= C_ACT && e <= C_PRE);
    openSel = mOpen[bank];
    avail = openSel && !(mAp == 1 && mApBank == bank);
    bad = 0;
    if (e == C_MRS || e == C_REF || e == C_SREF) bad = (mOpen != 0);
    else if (e == C_ACT) bad = openSel;
    else if (e >= C_RD && e <= C_WRA) bad = !avail || (mAp > 1);
    if (mLock > 0 && e != C_NOP) bad = 1;

    if (mAp == 1) mOpen[mApBank] = 1'b0;
    if (mAp > 0) mAp--;
    if (mLock > 0) mLock--;
    if (!bad) begin
      if (e == C_ACT) mOpen[bank] = 1'b1;
      if (e == C_PRE) mOpen[bank] = 1'b0;
      if (e == C_PALL) mOpen = '0;
      if (e == C_MRS) begin
        mLock = 1;
        mBl = modeOp[2] ? 1 : (1 << modeOp[1:0]);
      end
      if (e == C_RDA || e == C_WRA) begin
        mAp = mBl;
        mApBank = bank;
      end
    end
    expQ.push_back({4'(e), uses ? bank[1:0] : 2'd0, mOpen, bad, dq, h2});
    tagQ.push_back(tag);
    h2 = h1;
    h1 = dq;
  endtask

  // monitor
  initial begin
    forever begin
      @(posedge clk);
      #2;
      if (expQ.size() > 0)
        compare({cmdCode, cmdBank, bankOpen, illegalCmd, wrMask, rdHiZ},
                expQ.pop_front(), tagQ.pop_front());
    end
  end

  initial begin
    #(200000 * 10);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual running expected finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (4) @(posedge clk);
    #2;
    compare({cmdCode, cmdBank, bankOpen, illegalCmd, wrMask, rdHiZ}, 13'd0, "R9 in reset");
    @(negedge clk);
    rstN = 1'b1;
    @(posedge clk);
    #2;
    compare({cmdCode, cmdBank, bankOpen, illegalCmd, wrMask, rdHiZ}, 13'd0, "R9 after reset");

    // R5 lockout, R7 burst length 4 programmed
    modeOp = 3'b010;
    issue(C_MRS, 0, 0, "R5 mrs legal");
    issue(C_ACT, 0, 1, "R5 act in lockout");
    issue(C_ACT, 0, 0, "R5 act after gap");
    issue(C_ACT, 0, 1, "R8 act open bank");
    issue(C_RD, 1, 0, "R8 read closed bank");
    issue(C_ACT, 2, 1, "R2 act bank2");
    issue(C_WR, 2, 1, "R4 write no ap");
    issue(C_MRS, 0, 0, "R6 mrs banks open");
    issue(C_REF, 0, 0, "R6 ref banks open");
    issue(C_SREF, 0, 1, "R6 sref banks open");
    issue(C_PRE, 0, 0, "R3 pre bank0");
    issue(C_ACT, 3, 0, "R2 act bank3");
    issue(C_PALL, 1, 1, "R3 pall ignores ba");
    issue(C_REF, 0, 0, "R6 ref all closed");
    issue(C_SREF, 0, 0, "R6 sref all closed");
    issue(C_RSVD, 2, 1, "R1 reserved");
    issue(C_DESEL, 1, 0, "R1 deselect");
    issue(C_ACT, 1, 0, "R1 cke low ignored", 1'b0);

    // R7 auto precharge burst, BL=4
    issue(C_ACT, 0, 0, "R2 act bank0");
    issue(C_ACT, 1, 1, "R2 act bank1");
    issue(C_RDA, 0, 1, "R4 rda bank0");
    issue(C_RD, 1, 0, "R7 read inside burst");
    issue(C_NOP, 0, 1, "R7 burst beat");
    issue(C_NOP, 0, 0, "R7 burst beat");
    issue(C_RD, 1, 1, "R7 read at boundary");
    issue(C_RD, 0, 0, "R4 bank0 closed by ap");

    // R7 with BL=1, write auto precharge
    issue(C_PALL, 0, 0, "R3 pall");
    modeOp = 3'b000;
    issue(C_MRS, 0, 1, "R7 mrs bl1");
    issue(C_NOP, 0, 0, "R5 nop in lockout");
    issue(C_ACT, 3, 0, "R2 act bank3");
    issue(C_ACT, 2, 1, "R2 act bank2");
    issue(C_WRA, 3, 1, "R4 wra bank3");
    issue(C_RD, 3, 0, "R7 closing bank at boundary");
    issue(C_WR, 2, 1, "R7 write bank2 after burst");
    issue(C_PRE, 2, 0, "R3 pre bank2");
    issue(C_MRS, 0, 1, "R6 mrs all closed");
    issue(C_RSVD, 0, 0, "R5 reserved in lockout");
    issue(C_NOP, 0, 1, "R10 dqm pattern");
    issue(C_NOP, 0, 1, "R10 dqm pattern");
    issue(C_NOP, 0, 0, "R10 dqm pattern");
    issue(C_NOP, 0, 0, "R10 dqm pattern");
    issue(C_NOP, 0, 0, "R10 dqm pattern");

    repeat (3) @(posedge clk);
    #3;
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

endmodule